// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block is a real-time calendar clock that sits behind a byte-wide register bus. A one-cycle enable pulse, arriving once per second from an external divider, advances a packed-BCD count of seconds, minutes, hours, day of month, month, two-digit year and day of week. The count follows calendar rules, including month lengths and a 29-day February in years divisible by four. A six-field alarm is compared against the count on every advance.

Software stops the clock to load a new time and starts it again through a run bit. To read a consistent time, software first sets a capture bit, which freezes a copy of the six date fields into shadow registers, and then reads the copy byte by byte. Status flags record each elapsed second, minute, hour and day, each alarm hit, and a power-on marker. A flag is cleared by writing 1 to it. One level-type interrupt line combines the alarm flag with one selected periodic flag. It stays high until software clears the causing flag, so each new event gives the host a fresh rising edge.

Top module: `rtc_calendar_core`

## Requirements
- R1: A synchronous reset sets the time to 00:00:00, day 01, month 01, year 00, weekday 0, and clears the alarm fields, the run bit, the interrupt controls and both spare bytes. Status reads 0x80, with only the power-on flag set.
- R2: The register addresses are: seconds 0x00, minutes 0x01, hours 0x02, day 0x03, month 0x04, year 0x05, weekday 0x06, alarm seconds to alarm year 0x07 to 0x0C in the same field order, control 0x0D, status 0x0E, interrupt control 0x0F, and two read/write spare bytes at 0x10 and 0x11. Other addresses read 0x00.
- R3: With control bit 0 (run) at 1, each tick pulse advances the seconds by one. With run at 0, tick pulses are ignored and the count holds.
- R4: A write to 0x00 to 0x06 loads that field only while run is 0. While run is 1 such writes are ignored.
- R5: Writing control with bit 6 at 1 copies the live seconds to year into shadow registers in that cycle. Reads of 0x00 to 0x05 return the shadow copy. 0x06 returns the live weekday. Control reads back only bit 0.
- R6: Seconds and minutes wrap 59 to 00, hours wrap 23 to 00, day wraps past the month length to 01, month wraps 12 to 01 and carries into the year, and the year wraps 99 to 00. The weekday steps 0 to 6 and back to 0 each time the hours wrap.
- R7: April, June, September and November have 30 days. February has 29 days when the year value is a multiple of 4 and 28 days otherwise. All other months have 31.
- R8: Status bit 2 is set on every advance, bit 3 when seconds wrap, bit 4 when minutes wrap, and bit 5 when hours wrap. Bit 1 reads as the run bit and bit 0 reads 0.
- R9: Status bit 6 is set by an advance whose new seconds, minutes, hours, day, month and year all equal the alarm fields. The weekday is not compared, and loading a matching time while stopped sets nothing.
- R10: Writing status clears each of bits 7 to 2 written as 1 and leaves bits written as 0 unchanged. A flag set in the same cycle as its clear stays set.
- R11: The interrupt output goes high one cycle after status bit 6 is set while interrupt-control bit 3 is 1, or after the status bit selected by interrupt-control bits [1:0] (0 second, 1 minute, 2 hour, 3 day, i.e. status bit 2 plus the code) is set while bit 2 is 1. It falls one cycle after the cause is cleared. Interrupt-control bits 7 to 4 read 0.
- R12: Read data is registered. It takes the addressed value one cycle after a cycle with the read strobe high and holds while the strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt, sampled on its rising edge by the host |

## Verification
The hardest states to reach from the ports are the deep carries: a year rollover, a February end in leap and common years, and a 30-day month end. At one tick per second these would take years of simulated time. The stimulus stops the clock, loads a time one second before each boundary, restarts, and issues a single tick. The alarm and the periodic interrupt are reached the same way, by loading a time a few ticks short of the target. A behavioural model in the bench follows every cycle, including ticks, flag clears and writes that land in the same cycle.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int NUM_DATE = 6;   // sec, min, hour, day, month, year
  localparam int A_SEC    = 0;
  localparam int A_WDAY   = 6;
  localparam int A_ALM0   = 7;
  localparam int A_CTRL   = 13;
  localparam int A_STAT   = 14;
  localparam int A_IEN    = 15;
  localparam int A_SPARE0 = 16;

  localparam int CTRL_RUN  = 0;
  localparam int CTRL_SNAP = 6;
  localparam int ST_ALARM  = 6;
  localparam int ST_PWRUP  = 7;

  // index 0 = seconds ... index 5 = year, each packed BCD
  typedef logic [NUM_DATE-1:0][7:0] date_t;

  localparam date_t DATE_RESET = {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  function automatic logic [7:0] bcd_to_bin(input logic [7:0] b);
    return ({4'b0, b[7:4]} * 8'd10) + {4'b0, b[3:0]};
  endfunction

  function automatic logic [7:0] bin_to_bcd(input logic [7:0] v);
    logic [7:0] tens;
    logic [7:0] ones;
    tens = v / 8'd10;
    ones = v - (tens * 8'd10);
    return {tens[3:0], ones[3:0]};
  endfunction

  // month and year in binary; result in binary
  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
    logic [7:0] len;
    case (mon)
      8'd2:                      len = (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:   len = 8'd30;
      default:                   len = 8'd31;
    endcase
    return len;
  endfunction

endpackage

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       advance,
  input  logic       ld_en,
  input  logic [2:0] ld_idx,
  input  logic [7:0] ld_data,
  output date_t      date_q,
  output logic [7:0] wday_q,
  output date_t      date_nx,
  output logic [3:0] roll
);

  localparam logic [7:0] WDAY_LAST = 8'd6;

  logic [7:0] cur [NUM_DATE];
  logic [7:0] nxt [NUM_DATE];
  logic       carry [NUM_DATE];
  logic [7:0] mlen;
  logic       w_sec, w_min, w_hr, w_day, w_mon;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_DATE; gi++) begin : g_conv
      assign cur[gi]     = bcd_to_bin(date_q[gi]);
      assign date_nx[gi] = carry[gi] ? bin_to_bcd(nxt[gi]) : date_q[gi];
    end
  endgenerate

  always_comb begin
    mlen  = month_len(cur[4], cur[5]);
    w_sec = cur[0] >= 8'd59;
    w_min = cur[1] >= 8'd59;
    w_hr  = cur[2] >= 8'd23;
    w_day = cur[3] >= mlen;
    w_mon = cur[4] >= 8'd12;

    carry[0] = advance;
    carry[1] = carry[0] & w_sec;
    carry[2] = carry[1] & w_min;
    carry[3] = carry[2] & w_hr;
    carry[4] = carry[3] & w_day;
    carry[5] = carry[4] & w_mon;

    nxt[0] = w_sec ? 8'd0 : cur[0] + 8'd1;
    nxt[1] = w_min ? 8'd0 : cur[1] + 8'd1;
    nxt[2] = w_hr  ? 8'd0 : cur[2] + 8'd1;
    nxt[3] = w_day ? 8'd1 : cur[3] + 8'd1;
    nxt[4] = w_mon ? 8'd1 : cur[4] + 8'd1;
    nxt[5] = (cur[5] >= 8'd99) ? 8'd0 : cur[5] + 8'd1;

    roll = {carry[3], carry[2], carry[1], carry[0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      date_q <= DATE_RESET;
      wday_q <= 8'd0;
    end else if (ld_en) begin
      for (int i = 0; i < NUM_DATE; i++) begin
        if (ld_idx == 3'(i)) date_q[i] <= ld_data;
      end
      if (ld_idx == 3'(A_WDAY)) wday_q <= ld_data;
    end else if (advance) begin
      date_q <= date_nx;
      if (carry[3]) wday_q <= (wday_q >= WDAY_LAST) ? 8'd0 : wday_q + 8'd1;
    end
  end

endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [2:0] wr_idx,
  input  logic [7:0] wr_data,
  input  date_t      cand,
  output date_t      alarm_q,
  output logic       match
);

  logic [NUM_DATE-1:0] eq;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_DATE; gi++) begin : g_cmp
      assign eq[gi] = (cand[gi] == alarm_q[gi]);
    end
  endgenerate

  assign match = &eq;

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_q <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_DATE; i++) begin
        if (wr_idx == 3'(i)) alarm_q[i] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/rtc_event_unit.sv
module rtc_event_unit
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] roll,
  input  logic       alarm_hit,
  input  logic       st_we,
  input  logic       ien_we,
  input  logic [7:0] wdata,
  output logic [7:0] status_q,
  output logic [3:0] ien_q,
  output logic       irq_q
);

  logic [7:0] st_nx;
  logic [2:0] sel_pos;
  logic       irq_nx;

  always_comb begin
    sel_pos = {1'b0, ien_q[1:0]} + 3'd2;
    irq_nx  = (status_q[ST_ALARM] & ien_q[3]) | (status_q[sel_pos] & ien_q[2]);

    st_nx = status_q;
    if (st_we) st_nx[7:2] = status_q[7:2] & ~wdata[7:2];
    st_nx[5:2]      = st_nx[5:2] | roll;
    st_nx[ST_ALARM] = st_nx[ST_ALARM] | alarm_hit;
    st_nx[1:0]      = 2'b00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= 8'h80;
      ien_q    <= 4'h0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= st_nx;
      irq_q    <= irq_nx;
      if (ien_we) ien_q <= wdata[3:0];
    end
  end

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int SPARE_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1hz,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [7:0]        bus_rdata,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] ADR_WDAY = ADDR_W'(A_WDAY);
  localparam logic [ADDR_W-1:0] ADR_ALM0 = ADDR_W'(A_ALM0);
  localparam logic [ADDR_W-1:0] ADR_ALML = ADDR_W'(A_ALM0 + NUM_DATE - 1);
  localparam logic [ADDR_W-1:0] ADR_CTRL = ADDR_W'(A_CTRL);
  localparam logic [ADDR_W-1:0] ADR_STAT = ADDR_W'(A_STAT);
  localparam logic [ADDR_W-1:0] ADR_IEN  = ADDR_W'(A_IEN);

  logic              run_q;
  date_t             shadow_q;
  date_t             date_q;
  date_t             date_nx;
  date_t             alarm_q;
  logic [7:0]        wday_q;
  logic [3:0]        roll;
  logic              alarm_match;
  logic              advance;
  logic [7:0]        status_q;
  logic [3:0]        ien_q;
  logic              irq_q;
  logic [7:0]        rdata_q;
  logic [7:0]        rd_mux;
  logic [7:0]        spare_q [SPARE_BYTES];
  logic [ADDR_W-1:0] alm_off;
  logic              ld_en, alm_we, ctrl_we;

  assign advance = run_q & tick_1hz;
  assign ld_en   = bus_we & ~run_q & (bus_addr <= ADR_WDAY);
  assign alm_off = bus_addr - ADR_ALM0;
  assign alm_we  = bus_we & (bus_addr >= ADR_ALM0) & (bus_addr <= ADR_ALML);
  assign ctrl_we = bus_we & (bus_addr == ADR_CTRL);

  rtc_time_counter u_count (
    .clk     (clk),
    .rst     (rst),
    .advance (advance),
    .ld_en   (ld_en),
    .ld_idx  (bus_addr[2:0]),
    .ld_data (bus_wdata),
    .date_q  (date_q),
    .wday_q  (wday_q),
    .date_nx (date_nx),
    .roll    (roll)
  );

  rtc_alarm_unit u_alarm (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (alm_we),
    .wr_idx  (alm_off[2:0]),
    .wr_data (bus_wdata),
    .cand    (date_nx),
    .alarm_q (alarm_q),
    .match   (alarm_match)
  );

  rtc_event_unit u_event (
    .clk       (clk),
    .rst       (rst),
    .roll      (roll),
    .alarm_hit (advance & alarm_match),
    .st_we     (bus_we & (bus_addr == ADR_STAT)),
    .ien_we    (bus_we & (bus_addr == ADR_IEN)),
    .wdata     (bus_wdata),
    .status_q  (status_q),
    .ien_q     (ien_q),
    .irq_q     (irq_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      shadow_q <= DATE_RESET;
    end else if (ctrl_we) begin
      run_q <= bus_wdata[CTRL_RUN];
      if (bus_wdata[CTRL_SNAP]) shadow_q <= date_q;
    end
  end

  genvar gk;
  generate
    for (gk = 0; gk < SPARE_BYTES; gk++) begin : g_spare
      always_ff @(posedge clk) begin
        if (rst) spare_q[gk] <= 8'h00;
        else if (bus_we && bus_addr == ADDR_W'(A_SPARE0 + gk)) spare_q[gk] <= bus_wdata;
      end
    end
  endgenerate

  always_comb begin
    rd_mux = 8'h00;
    for (int i = 0; i < NUM_DATE; i++) begin
      if (bus_addr == ADDR_W'(A_SEC + i))  rd_mux = shadow_q[i];
      if (bus_addr == ADDR_W'(A_ALM0 + i)) rd_mux = alarm_q[i];
    end
    for (int k = 0; k < SPARE_BYTES; k++) begin
      if (bus_addr == ADDR_W'(A_SPARE0 + k)) rd_mux = spare_q[k];
    end
    if (bus_addr == ADR_WDAY) rd_mux = wday_q;
    if (bus_addr == ADR_CTRL) rd_mux = {7'b0, run_q};
    if (bus_addr == ADR_STAT) rd_mux = {status_q[7:2], run_q, 1'b0};
    if (bus_addr == ADR_IEN)  rd_mux = {4'b0, ien_q};
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= 8'h00;
    else if (bus_re) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;

endmodule

// File: rtl/rtc_calendar_checks.sv
module rtc_calendar_checks
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_1hz,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              bus_we,
  input logic              bus_re,
  input logic [7:0]        bus_rdata,
  input logic              irq,
  input logic              run_q,
  input date_t             date_q,
  input date_t             shadow_q,
  input logic [7:0]        status_q,
  input logic [3:0]        ien_q
);

  localparam logic [ADDR_W-1:0] C_CTRL = ADDR_W'(A_CTRL);
  localparam logic [ADDR_W-1:0] C_STAT = ADDR_W'(A_STAT);

  a_r3_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !bus_we) |=> $stable(date_q));

  a_r4_running_ignores_writes: assert property (@(posedge clk) disable iff (rst)
    (run_q && !tick_1hz) |=> $stable(date_q));

  a_r5_snapshot_copies: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == C_CTRL && bus_wdata[6]) |=> (shadow_q == $past(date_q)));

  a_r8_second_flag: assert property (@(posedge clk) disable iff (rst)
    (run_q && tick_1hz) |=> status_q[2]);

  a_r10_pwrup_clears: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == C_STAT && bus_wdata[7]) |=> !status_q[7]);

  a_r11_alarm_irq: assert property (@(posedge clk) disable iff (rst)
    (status_q[6] && ien_q[3]) |=> irq);

  a_r12_rdata_holds: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> $stable(bus_rdata));

endmodule

bind rtc_calendar_core rtc_calendar_checks #(.ADDR_W(ADDR_W)) u_checks (
  .clk       (clk),
  .rst       (rst),
  .tick_1hz  (tick_1hz),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_we    (bus_we),
  .bus_re    (bus_re),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .run_q     (run_q),
  .date_q    (date_q),
  .shadow_q  (shadow_q),
  .status_q  (status_q),
  .ien_q     (ien_q)
);

// File: tb/test_rtc_calendar_core.sv
module test_rtc_calendar_core;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_1hz = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_we = 1'b0;
  logic       bus_re = 1'b0;
  logic [7:0] bus_rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit armed  = 1'b0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  rtc_calendar_core i_rtc_calendar_core (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  int t [6];       // binary sec, min, hour, day, month, year
  int wd;
  int al [6];      // raw alarm bytes
  int sh [6];      // binary shadow
  int m_run, m_st, m_ie, m_rd, m_irq;
  int sp [2];

  function automatic int to_bcd(int v); return ((v / 10) << 4) | (v % 10); endfunction
  function automatic int from_bcd(int b); return ((b >> 4) & 15) * 10 + (b & 15); endfunction

  function automatic int days_of(int mon, int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic int m_read(int a);
    if (a <= 5) return to_bcd(sh[a]);
    if (a == 6) return wd;
    if (a >= 7 && a <= 12) return al[a-7];
    if (a == 13) return m_run;
    if (a == 14) return (m_st & 'hFC) | (m_run << 1);
    if (a == 15) return m_ie;
    if (a == 16 || a == 17) return sp[a-16];
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      t[0] = 0; t[1] = 0; t[2] = 0; t[3] = 1; t[4] = 1; t[5] = 0; wd = 0;
      for (int i = 0; i < 6; i++) begin al[i] = 0; sh[i] = t[i]; end
      m_run = 0; m_st = 'h80; m_ie = 0; m_rd = 0; m_irq = 0; sp[0] = 0; sp[1] = 0;
    end else begin
      int ot [6];
      int ev, sel, a;
      bit hit;
      a = int'(bus_addr);
      if (bus_re) m_rd = m_read(a);
      sel = m_ie & 3;
      m_irq = ((((m_st >> 6) & 1) == 1) && ((m_ie & 8) != 0)) ||
              ((((m_st >> (2 + sel)) & 1) == 1) && ((m_ie & 4) != 0));
      for (int i = 0; i < 6; i++) ot[i] = t[i];
      ev = 0; hit = 0;
      if (m_run == 1 && tick_1hz) begin
        ev |= 'h04; t[0]++;
        if (t[0] == 60) begin
          t[0] = 0; ev |= 'h08; t[1]++;
          if (t[1] == 60) begin
            t[1] = 0; ev |= 'h10; t[2]++;
            if (t[2] == 24) begin
              t[2] = 0; ev |= 'h20; wd = (wd + 1) % 7; t[3]++;
              if (t[3] > days_of(t[4], t[5])) begin
                t[3] = 1; t[4]++;
                if (t[4] == 13) begin t[4] = 1; t[5] = (t[5] + 1) % 100; end
              end
            end
          end
        end
        hit = 1;
        for (int i = 0; i < 6; i++) if (to_bcd(t[i]) != al[i]) hit = 0;
      end
      if (bus_we) begin
        if (a <= 5 && m_run == 0) t[a] = from_bcd(int'(bus_wdata));
        if (a == 6 && m_run == 0) wd = int'(bus_wdata);
        if (a >= 7 && a <= 12) al[a-7] = int'(bus_wdata);
        if (a == 13) begin
          m_run = int'(bus_wdata[0]);
          if (bus_wdata[6]) for (int i = 0; i < 6; i++) sh[i] = ot[i];
        end
        if (a == 14) m_st = m_st & ~(int'(bus_wdata) & 'hFC);
        if (a == 15) m_ie = int'(bus_wdata) & 15;
        if (a == 16 || a == 17) sp[a-16] = int'(bus_wdata);
      end
      m_st = m_st | ev | (hit ? 'h40 : 0);
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison with the model
  always @(negedge clk) begin
    if (armed && !done) begin
      check("R12 rdata vs model", int'(bus_rdata), m_rd);
      check("R11 irq vs model", int'(irq), m_irq);
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(bit we, bit re, int a, int d, bit tk);
    bus_we = we; bus_re = re; bus_addr = 5'(a); bus_wdata = 8'(d); tick_1hz = tk;
    @(negedge clk);
  endtask
  task automatic wr(int a, int d); cyc(1, 0, a, d, 0); endtask
  task automatic tick(); cyc(0, 0, 0, 0, 1); endtask
  task automatic idle(); cyc(0, 0, 0, 0, 0); endtask
  task automatic rdchk(int a, int exp, string tag);
    cyc(0, 1, a, 0, 0);
    check(tag, int'(bus_rdata), exp);
  endtask
  task automatic load(int s, int mi, int h, int d, int mo, int y);
    wr(0, s); wr(1, mi); wr(2, h); wr(3, d); wr(4, mo); wr(5, y);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    armed = 1'b1;

    // R1 reset state
    rdchk(14, 'h80, "R1 status");
    rdchk(15, 'h00, "R1 int ctrl");
    rdchk(13, 'h00, "R1 control");
    rdchk(6,  'h00, "R1 weekday");
    rdchk(7,  'h00, "R1 alarm sec");
    wr(13, 'h40);
    rdchk(0, 'h00, "R1 sec"); rdchk(3, 'h01, "R1 day");
    rdchk(4, 'h01, "R1 month"); rdchk(5, 'h00, "R1 year");

    // R4 load, R6 full carry chain, R8 flags, R5 snapshot
    load('h58, 'h59, 'h23, 'h31, 'h12, 'h99); wr(6, 6);
    wr(13, 1); tick(); wr(13, 'h41);
    rdchk(0, 'h59, "R4 sec loaded"); rdchk(3, 'h31, "R4 day loaded");
    rdchk(5, 'h99, "R4 year loaded");
    tick();
    rdchk(0, 'h59, "R5 shadow stays until capture");
    wr(13, 'h41);
    rdchk(0, 'h00, "R6 sec wrap"); rdchk(1, 'h00, "R6 min wrap");
    rdchk(2, 'h00, "R6 hour wrap"); rdchk(3, 'h01, "R6 day wrap");
    rdchk(4, 'h01, "R6 month wrap"); rdchk(5, 'h00, "R6 year wrap");
    rdchk(6, 'h00, "R6 weekday wrap");
    rdchk(14, 'hBE, "R8 roll flags");
    rdchk(13, 'h01, "R5 capture bit reads 0");

    // R10 write-one-to-clear
    wr(14, 'hFF);
    rdchk(14, 'h02, "R10 all cleared");
    tick(); wr(14, 'h00);
    rdchk(14, 'h06, "R10 zero write keeps");
    cyc(1, 0, 14, 'h04, 1);
    rdchk(14, 'h06, "R10 set wins");

    // R4 write ignored while running, R3 stopped holds
    wr(0, 'h30); wr(13, 'h41);
    rdchk(0, 'h02, "R4 write ignored");
    wr(13, 0); repeat (5) tick(); wr(13, 'h40);
    rdchk(0, 'h02, "R3 stopped");

    // R7 month lengths
    load('h59, 'h59, 'h23, 'h28, 'h02, 'h24); wr(13, 1); tick(); wr(13, 'h40);
    rdchk(3, 'h29, "R7 leap feb day"); rdchk(4, 'h02, "R7 leap feb month");
    load('h59, 'h59, 'h23, 'h28, 'h02, 'h23); wr(13, 1); tick(); wr(13, 'h40);
    rdchk(3, 'h01, "R7 common feb day"); rdchk(4, 'h03, "R7 common feb month");
    load('h59, 'h59, 'h23, 'h30, 'h04, 'h23); wr(13, 1); tick(); wr(13, 'h40);
    rdchk(3, 'h01, "R7 april day"); rdchk(4, 'h05, "R7 april month");

    // R9 alarm, R11 alarm interrupt
    load('h10, 0, 0, 'h05, 'h06, 'h07); wr(6, 3);
    wr(7, 'h12); wr(8, 0); wr(9, 0); wr(10, 'h05); wr(11, 'h06); wr(12, 'h07);
    wr(15, 'h08); wr(14, 'hFF); wr(13, 1);
    tick(); idle();
    check("R9 no hit before match", int'(irq), 0);
    tick();
    check("R11 irq registered delay", int'(irq), 0);
    rdchk(14, 'h46, "R9 alarm flag");
    check("R11 alarm irq high", int'(irq), 1);
    wr(14, 'h40);
    check("R11 irq before clear lands", int'(irq), 1);
    idle();
    check("R11 irq falls", int'(irq), 0);

    // R11 periodic select (minute)
    wr(15, 'h05); wr(14, 'hFF);
    tick(); idle();
    check("R11 second flag not selected", int'(irq), 0);
    wr(13, 0); wr(0, 'h59); wr(13, 1);
    tick(); idle();
    check("R11 minute irq", int'(irq), 1);
    wr(14, 'h08); idle();
    check("R11 minute irq cleared", int'(irq), 0);
    rdchk(15, 'h05, "R11 int ctrl readback");

    // R2 spare bytes and unmapped, R12 hold
    wr(16, 'hA5); wr(17, 'h3C);
    rdchk(16, 'hA5, "R2 spare0");
    cyc(0, 0, 17, 0, 0);
    check("R12 hold without strobe", int'(bus_rdata), 'hA5);
    rdchk(17, 'h3C, "R2 spare1");
    rdchk(31, 'h00, "R2 unmapped");
    rdchk(12, 'h07, "R2 alarm year");

    idle();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule